// File: doc/BRIEF.md
# Backup Clock Failover and Reset Stretch Supervisor

This block chooses between two system clock sources: the PLL output, or a free-running on-chip ring oscillator kept as a fallback. It also owns the chip's hard-reset output. Reset requests come from an external pin and from a software fallback command. The block stretches those requests into a reset pulse of guaranteed minimum length. Under one configuration bit, it can also keep the chip in reset while the PLL has no lock. The block does not contain the oscillators or the multiplexer. It drives a registered select level for an external clock mux and reports the active source on a status pin.

A single configuration bit decides what happens when the PLL loses lock while hard reset is asserted. With the bit clear and fallback operation allowed, the block moves the system onto the ring oscillator. With the bit set, the clock choice is left alone and the reset is simply held until the PLL locks again. Once the ring oscillator has been chosen, only a power-on reset brings the selection back to the PLL.

Top module: `bkclk_supervisor`

## Requirements
- R1: The PLL lock input passes through exactly two synchronizing flip-flops before any decision uses it. With reset being held for missing lock, raising the lock input makes the hard-reset output fall after the 11th rising clock edge (2 synchronizer edges, plus the reload edge, plus 8 stretch edges).
- R2: While hard reset is asserted, limp mode is enabled and the hold-on-unlock bit is 0, a fall of the synchronized lock signal from 1 to 0 selects the backup clock (`clk_sel` = 1). With limp mode disabled, the same event leaves `clk_sel` at 0.
- R3: While the hold-on-unlock bit is 1, a loss of PLL lock never changes `clk_sel`.
- R4: While the hold-on-unlock bit is 1 and hard reset is asserted, hard reset stays asserted for as long as the synchronized lock is 0.
- R5: A software fallback request sampled while limp mode is enabled sets `clk_sel` to 1 and asserts `hreset` at the next clock edge.
- R6: A software fallback request sampled while limp mode is disabled changes neither `clk_sel` nor `hreset`.
- R7: Once `clk_sel` is 1 it stays 1 until `por_n` is driven low. After power-on reset, `clk_sel` is 0.
- R8: `hreset` stays 1 for the 8 clock edges that follow the last edge at which a reset cause was sampled. It falls at the 9th such edge.
- R9: `on_backup` is 1 exactly when the backup clock is selected.
- R10: While `por_n` is low, `clk_sel` = 0, `on_backup` = 0 and `hreset` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| por_n | input | 1 | Power-on reset, active low. Asserts asynchronously and is released synchronously inside the block |
| pll_locked | input | 1 | PLL lock indicator, asynchronous to `clk` |
| rst_req | input | 1 | Raw hard-reset request, active high |
| limp_en | input | 1 | 1 = fallback to the backup clock is permitted |
| hold_on_unlock | input | 1 | 1 = lock loss during reset holds reset and keeps the clock choice. 0 = lock loss during reset fails over |
| sw_fallback | input | 1 | Software request to move to the backup clock and reset the chip |
| clk_sel | output | 1 | Registered mux select: 0 = PLL, 1 = backup oscillator |
| on_backup | output | 1 | Status: backup clock is the current source |
| hreset | output | 1 | Stretched hard reset, active high |

## Verification
The hardest state to reach from the ports is a lock *loss* during reset. The synchronized lock must first have been seen high, and then go low while `hreset` is still asserted. Otherwise the power-up period, when lock has never been seen, would look like a loss. To get there, the stimulus lets the PLL lock settle through the synchronizer after power-on and then raises `rst_req`. Only after that does it drop `pll_locked`, so the falling edge lands inside the reset window. A similar ordering is used for the held-reset case: reset is first held with lock missing, then lock is restored, and the release edge is counted exactly. This confirms the synchronizer depth and the stretch length together.

// File: rtl/bkclk_pkg.sv
package bkclk_pkg;

  typedef enum logic {
    SRC_PLL    = 1'b0,
    SRC_BACKUP = 1'b1
  } clk_src_e;

  localparam int unsigned DEF_STRETCH = 8;
  localparam int unsigned DEF_SYNC    = 2;

endpackage

// File: rtl/bkclk_sync.sv
module bkclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_n = d;
    end else begin : g_chain
      always_comb stg_n = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_n;
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/bkclk_select.sv
module bkclk_select
  import bkclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     limp_en,
  input  logic     hold_bit,
  input  logic     sw_req,
  input  logic     hreset_i,
  input  logic     lock_s,
  output clk_src_e src_o,
  output logic     sw_go_o
);

  clk_src_e src_q, src_n;
  logic     lock_d_q, lock_d_n;
  logic     lock_lost;
  logic     failover;
  logic     sw_go;

  // A loss is a 1->0 transition of the synchronized lock, so the
  // never-locked power-up period does not count as one.
  always_comb begin
    lock_d_n  = lock_s;
    lock_lost = lock_d_q & ~lock_s;
    failover  = limp_en & ~hold_bit & hreset_i & lock_lost;
    sw_go     = limp_en & sw_req;
    if (src_q == SRC_BACKUP || sw_go || failover) src_n = SRC_BACKUP;
    else                                          src_n = SRC_PLL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= SRC_PLL;
      lock_d_q <= 1'b0;
    end else begin
      src_q    <= src_n;
      lock_d_q <= lock_d_n;
    end
  end

  assign src_o   = src_q;
  assign sw_go_o = sw_go;

  // R7
  sticky_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_BACKUP) |=> (src_q == SRC_BACKUP));

  // R3
  hold_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_bit && !sw_req) |=> $stable(src_q));

  // R6
  no_limp_no_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !limp_en |=> $stable(src_q));

endmodule

// File: rtl/bkclk_stretch.sv
module bkclk_stretch #(
  parameter int unsigned STRETCH_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cause_i,
  output logic hreset_o
);

  localparam int unsigned CW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          hr_q, hr_n;

  always_comb begin
    cnt_n = cnt_q;
    hr_n  = 1'b0;
    if (cause_i) begin
      cnt_n = LOAD;
      hr_n  = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
      hr_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOAD;
      hr_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      hr_q  <= hr_n;
    end
  end

  assign hreset_o = hr_q;

  // Checker: consecutive edges with no reset cause, saturating.
  logic [CW:0] quiet_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         quiet_q <= '0;
    else if (cause_i)                   quiet_q <= '0;
    else if (quiet_q != {(CW+1){1'b1}}) quiet_q <= quiet_q + 1'b1;
  end

  // R8
  min_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hr_q) |-> (quiet_q >= (CW+1)'(STRETCH_CYC)));

endmodule

// File: rtl/bkclk_supervisor.sv
module bkclk_supervisor
  import bkclk_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = DEF_STRETCH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic clk,
  input  logic por_n,
  input  logic pll_locked,
  input  logic rst_req,
  input  logic limp_en,
  input  logic hold_on_unlock,
  input  logic sw_fallback,
  output logic clk_sel,
  output logic on_backup,
  output logic hreset
);

  logic     rst_n_sync;
  logic     lock_s;
  logic     sw_go;
  logic     hold_rst;
  logic     cause;
  logic     hr;
  clk_src_e src;

  bkclk_sync #(.STAGES(2)) u_por_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (1'b1),
    .q     (rst_n_sync)
  );

  bkclk_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d     (pll_locked),
    .q     (lock_s)
  );

  bkclk_select u_sel (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .limp_en  (limp_en),
    .hold_bit (hold_on_unlock),
    .sw_req   (sw_fallback),
    .hreset_i (hr),
    .lock_s   (lock_s),
    .src_o    (src),
    .sw_go_o  (sw_go)
  );

  always_comb begin
    hold_rst = hold_on_unlock & hr & ~lock_s;
    cause    = rst_req | sw_go | hold_rst;
  end

  bkclk_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .cause_i  (cause),
    .hreset_o (hr)
  );

  assign clk_sel   = (src == SRC_BACKUP);
  assign on_backup = (src == SRC_BACKUP);
  assign hreset    = hr;

  // R4
  hold_until_lock_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (hold_on_unlock && hr && !lock_s) |=> hr);

  // R5
  sw_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (limp_en && sw_fallback) |=> (clk_sel && hreset));

endmodule

// File: tb/bkclk_supervisor_test.sv
module bkclk_supervisor_test;

  logic clk = 1'b0;
  logic por_n, pll_locked, rst_req, limp_en, hold_on_unlock, sw_fallback;
  logic clk_sel, on_backup, hreset;
  int   n_chk = 0;
  int   n_bad = 0;

  always #4 clk = ~clk;

  bkclk_supervisor uut (
    .clk            (clk),
    .por_n          (por_n),
    .pll_locked     (pll_locked),
    .rst_req        (rst_req),
    .limp_en        (limp_en),
    .hold_on_unlock (hold_on_unlock),
    .sw_fallback    (sw_fallback),
    .clk_sel        (clk_sel),
    .on_backup      (on_backup),
    .hreset         (hreset)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    cyc(3);
    chk("R10 sel in por", clk_sel, 1'b0);
    chk("R10 status in por", on_backup, 1'b0);
    chk("R10 hreset in por", hreset, 1'b1);
    por_n = 1'b1;
    cyc(20);
    chk("R7 sel after por", clk_sel, 1'b0);
    chk("R10 hreset released", hreset, 1'b0);
  endtask

  task automatic t_stretch();
    rst_req = 1'b1;
    cyc(3);
    chk("R8 hreset during request", hreset, 1'b1);
    rst_req = 1'b0;
    cyc(8);
    chk("R8 hreset after 8 edges", hreset, 1'b1);
    cyc(1);
    chk("R8 hreset after 9 edges", hreset, 1'b0);
  endtask

  task automatic t_failover();
    limp_en = 1'b1; hold_on_unlock = 1'b0;
    rst_req = 1'b1;
    cyc(3);
    pll_locked = 1'b0;
    cyc(5);
    chk("R2 failover sel", clk_sel, 1'b1);
    chk("R9 status on backup", on_backup, 1'b1);
    rst_req = 1'b0; pll_locked = 1'b1;
    cyc(20);
    chk("R7 sel sticky", clk_sel, 1'b1);
    chk("R8 hreset released", hreset, 1'b0);
    do_por();
  endtask

  task automatic t_no_limp();
    limp_en = 1'b0; hold_on_unlock = 1'b0;
    rst_req = 1'b1;
    cyc(3);
    pll_locked = 1'b0;
    cyc(5);
    chk("R2 no failover without limp", clk_sel, 1'b0);
    chk("R9 status on pll", on_backup, 1'b0);
    rst_req = 1'b0; pll_locked = 1'b1;
    cyc(20);
    limp_en = 1'b1;
  endtask

  task automatic t_hold();
    limp_en = 1'b1; hold_on_unlock = 1'b1;
    rst_req = 1'b1;
    cyc(3);
    pll_locked = 1'b0;
    cyc(5);
    rst_req = 1'b0;
    cyc(30);
    chk("R4 reset held unlocked", hreset, 1'b1);
    chk("R3 sel unchanged", clk_sel, 1'b0);
    pll_locked = 1'b1;
    cyc(10);
    chk("R1 hreset after 10 edges", hreset, 1'b1);
    cyc(1);
    chk("R1 hreset after 11 edges", hreset, 1'b0);
    chk("R3 sel still pll", clk_sel, 1'b0);
    hold_on_unlock = 1'b0;
  endtask

  task automatic t_sw();
    limp_en = 1'b1;
    sw_fallback = 1'b1;
    cyc(1);
    sw_fallback = 1'b0;
    chk("R5 sw sel", clk_sel, 1'b1);
    chk("R5 sw hreset", hreset, 1'b1);
    cyc(20);
    chk("R8 hreset after sw", hreset, 1'b0);
    chk("R7 sel sticky after sw", clk_sel, 1'b1);
    do_por();
  endtask

  task automatic t_sw_ignored();
    limp_en = 1'b0;
    sw_fallback = 1'b1;
    cyc(1);
    chk("R6 sel ignored", clk_sel, 1'b0);
    chk("R6 hreset ignored", hreset, 1'b0);
    cyc(2);
    chk("R6 sel ignored held", clk_sel, 1'b0);
    chk("R6 hreset ignored held", hreset, 1'b0);
    sw_fallback = 1'b0;
    limp_en = 1'b1;
  endtask

  initial begin
    por_n = 1'b0; pll_locked = 1'b1; rst_req = 1'b0;
    limp_en = 1'b1; hold_on_unlock = 1'b0; sw_fallback = 1'b0;
    do_por();
    t_stretch();
    t_failover();
    t_no_limp();
    t_hold();
    t_sw();
    t_sw_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule